// File: doc/BRIEF.md
# Layered Strip Coincidence Trigger

This block forms an event trigger for a stack of detector layers. Each layer has two orthogonal pick-up planes (views X and Y) with 32 digital strip hits each. Every hit is first held for a programmable number of clock cycles, so hits that arrive at slightly different times can still coincide. Within a plane, strips are folded at a stride of eight into eight group signals. A plane then reports an m-fold hit when m neighbouring groups are active together. Group adjacency wraps around, so the last group and the first group are neighbours.

Across the stack, a combination (m,n) is met when n consecutive layers of the same view each show at least an m-fold hit. Four pairings are evaluated: (1,5), (2,4), (3,3) and (4,2). A per-combination enable mask picks the ones that may fire. The trigger output is a one-cycle pulse on the start of a qualifying condition, followed by a programmable dead time. The block also gives each plane an OR-of-groups timing output, which can serve as a time-measurement stop.

Top module: `layer_coinc_trig`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `trigOut`, `timingX` and `timingY` are all zero.
- R2: Strip hit bit `layer*32 + s` (s = 0..31) belongs to group s mod 8 of that layer's plane. Any strip of a group activates that group.
- R3: A plane shows m-fold (m = 1..4) when m groups with consecutive indices are active at once. Index 7 is adjacent to index 0. Two active groups that are not adjacent do not make 2-fold.
- R4: Combination c (c = 0..3) is met when 5−c consecutive layers (by layer index, no wrap from the last layer to layer 0) each show at least (c+1)-fold in one view. One layer fewer than that depth does not meet it.
- R5: Combinations are evaluated per view, and the trigger is the OR of both views. Layers of one view never fill in for layers of the other view.
- R6: Each strip hit is held active for `windowLen` cycles from the clock edge that samples it. Hits sampled fewer than `windowLen` edges apart coincide; hits `windowLen` or more edges apart do not. A `windowLen` of zero suppresses all hits.
- R7: Bit c of `comboEnable` lets combination c (bit 0 = (1,5), bit 1 = (2,4), bit 2 = (3,3), bit 3 = (4,2)) cause a trigger. A met combination with its bit clear causes none.
- R8: `trigOut` is a one-cycle pulse. It appears in the fourth cycle after the edge sampling the hit that completes the condition, and only when the enabled condition newly starts. A condition that persists does not pulse again.
- R9: After a pulse in cycle t, conditions starting so that they would pulse in cycles t+1..t+`deadTime` are dropped, not delayed. From cycle t+`deadTime`+1 onward, new conditions are accepted.
- R10: `timingX[l]` / `timingY[l]` is the OR of all held strips of that plane. It goes high in the second cycle after the edge sampling a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hitX | input | NUM_LAYERS*NSTRIPS | Strip hits of view X, layer-major |
| hitY | input | NUM_LAYERS*NSTRIPS | Strip hits of view Y, layer-major |
| windowLen | input | WIN_W | Hold length of each hit in cycles |
| comboEnable | input | 4 | Enable per (m,n) combination |
| deadTime | input | DEAD_W | Cycles blocked after each trigger pulse |
| trigOut | output | 1 | Final trigger pulse |
| timingX | output | NUM_LAYERS | Per-layer OR timing signal, view X |
| timingY | output | NUM_LAYERS | Per-layer OR timing signal, view Y |

## Verification
Each result has a fixed delay from the clock edge that samples a hit. The timing outputs follow after two register stages (hold counter, fold register). The trigger follows after four (hold counter, fold register, combination register, pulse register). The driver stamps every stimulus with the cycle count of its sampling edge and queues expected values for those exact later cycles. A monitor samples two nanoseconds after each rising edge and compares them. Every trigger pulse that no queued item predicts counts as a mismatch, so repeated pulses and dead-time leaks are caught as well as missing ones.

// File: rtl/lsct_pkg.sv
package lsct_pkg;
  // number of fold levels; combination c pairs fold c+1 with depth DEPTH_SUM-c-1
  localparam int FOLD_MAX = 4;

  typedef struct packed {
    logic [FOLD_MAX-1:0] viewX;
    logic [FOLD_MAX-1:0] viewY;
  } comboStatus_t;
endpackage

// File: rtl/lsct_stretch.sv
module lsct_stretch #(
  parameter int WIDTH = 32,
  parameter int WIN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] hitIn,
  input  logic [WIN_W-1:0] windowLen,
  output logic [WIDTH-1:0] heldOut
);
  logic [WIN_W-1:0] holdCnt [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 holdCnt[i] <= '0;
      else if (hitIn[i])         holdCnt[i] <= windowLen;
      else if (holdCnt[i] != '0) holdCnt[i] <= holdCnt[i] - 1'b1;
    end
    assign heldOut[i] = (holdCnt[i] != '0);
  end
endmodule

// File: rtl/lsct_plane_fold.sv
module lsct_plane_fold
  import lsct_pkg::*;
#(
  parameter int NSTRIPS = 32,
  parameter int NGROUPS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NSTRIPS-1:0]  stripIn,
  output logic [FOLD_MAX-1:0] foldOut,
  output logic                orOut
);
  localparam int PER_GROUP = NSTRIPS / NGROUPS;

  logic [NGROUPS-1:0]  grp;
  logic [FOLD_MAX-1:0] foldNext;

  // stride fold: strip s lands in group s mod NGROUPS
  always_comb begin
    grp = '0;
    for (int g = 0; g < NGROUPS; g++)
      for (int k = 0; k < PER_GROUP; k++)
        grp[g] = grp[g] | stripIn[k*NGROUPS + g];
  end

  // circular run of m active groups
  always_comb begin : p_fold
    logic run;
    foldNext = '0;
    for (int m = 1; m <= FOLD_MAX; m++) begin
      for (int s = 0; s < NGROUPS; s++) begin
        run = 1'b1;
        for (int j = 0; j < m; j++)
          run = run & grp[(s + j) % NGROUPS];
        foldNext[m-1] = foldNext[m-1] | run;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foldOut <= '0;
      orOut   <= 1'b0;
    end else begin
      foldOut <= foldNext;
      orOut   <= |grp;
    end
  end
endmodule

// File: rtl/lsct_datapath.sv
module lsct_datapath
  import lsct_pkg::*;
#(
  parameter int NUM_LAYERS = 14,
  parameter int NSTRIPS    = 32,
  parameter int NGROUPS    = 8,
  parameter int DEPTH_SUM  = 6,
  parameter int WIN_W      = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LAYERS*NSTRIPS-1:0] hitX,
  input  logic [NUM_LAYERS*NSTRIPS-1:0] hitY,
  input  logic [WIN_W-1:0]              windowLen,
  output comboStatus_t                  status,
  output logic [NUM_LAYERS-1:0]         timingX,
  output logic [NUM_LAYERS-1:0]         timingY
);
  localparam int BUS_W   = NUM_LAYERS * NSTRIPS;
  localparam int NVIEWS  = 2;

  logic [BUS_W-1:0]      hitV  [NVIEWS];
  logic [BUS_W-1:0]      heldV [NVIEWS];
  logic [FOLD_MAX-1:0]   foldV [NVIEWS][NUM_LAYERS];
  logic [NUM_LAYERS-1:0] orV   [NVIEWS];
  logic [NVIEWS*FOLD_MAX-1:0] comboNext, comboReg;

  assign hitV[0] = hitX;
  assign hitV[1] = hitY;

  for (genvar v = 0; v < NVIEWS; v++) begin : g_view
    lsct_stretch #(.WIDTH(BUS_W), .WIN_W(WIN_W)) u_stretch (
      .clk(clk), .rstN(rstN), .hitIn(hitV[v]),
      .windowLen(windowLen), .heldOut(heldV[v])
    );

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
      lsct_plane_fold #(.NSTRIPS(NSTRIPS), .NGROUPS(NGROUPS)) u_fold (
        .clk(clk), .rstN(rstN),
        .stripIn(heldV[v][l*NSTRIPS +: NSTRIPS]),
        .foldOut(foldV[v][l]), .orOut(orV[v][l])
      );
    end

    // combination c: fold c+1 in DEPTH consecutive layers
    for (genvar c = 0; c < FOLD_MAX; c++) begin : g_combo
      localparam int DEPTH  = DEPTH_SUM - c - 1;
      localparam int STARTS = NUM_LAYERS - DEPTH + 1;
      logic [STARTS-1:0] startHit;
      for (genvar s = 0; s < STARTS; s++) begin : g_start
        logic [DEPTH-1:0] col;
        for (genvar j = 0; j < DEPTH; j++) begin : g_col
          assign col[j] = foldV[v][s+j][c];
        end
        assign startHit[s] = &col;
      end
      assign comboNext[v*FOLD_MAX + c] = |startHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) comboReg <= '0;
    else       comboReg <= comboNext;
  end

  assign status.viewX = comboReg[FOLD_MAX-1:0];
  assign status.viewY = comboReg[2*FOLD_MAX-1:FOLD_MAX];
  assign timingX      = orV[0];
  assign timingY      = orV[1];
endmodule

// File: rtl/lsct_control.sv
module lsct_control
  import lsct_pkg::*;
#(
  parameter int DEAD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  comboStatus_t        status,
  input  logic [FOLD_MAX-1:0] comboEnable,
  input  logic [DEAD_W-1:0]   deadTime,
  output logic                trigOut
);
  logic              cond, condPrev, fire;
  logic [DEAD_W-1:0] deadCnt;

  assign cond = |((status.viewX | status.viewY) & comboEnable);
  assign fire = cond && !condPrev && (deadCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev <= 1'b0;
      trigOut  <= 1'b0;
      deadCnt  <= '0;
    end else begin
      condPrev <= cond;
      trigOut  <= fire;
      if (fire)                deadCnt <= deadTime;
      else if (deadCnt != '0)  deadCnt <= deadCnt - 1'b1;
    end
  end
endmodule

// File: rtl/layer_coinc_trig.sv
module layer_coinc_trig
  import lsct_pkg::*;
#(
  parameter int NUM_LAYERS = 14,
  parameter int NSTRIPS    = 32,
  parameter int NGROUPS    = 8,
  parameter int DEPTH_SUM  = 6,
  parameter int WIN_W      = 6,
  parameter int DEAD_W     = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_LAYERS*NSTRIPS-1:0] hitX,
  input  logic [NUM_LAYERS*NSTRIPS-1:0] hitY,
  input  logic [WIN_W-1:0]              windowLen,
  input  logic [FOLD_MAX-1:0]           comboEnable,
  input  logic [DEAD_W-1:0]             deadTime,
  output logic                          trigOut,
  output logic [NUM_LAYERS-1:0]         timingX,
  output logic [NUM_LAYERS-1:0]         timingY
);
  comboStatus_t dpStatus;

  lsct_datapath #(
    .NUM_LAYERS(NUM_LAYERS), .NSTRIPS(NSTRIPS), .NGROUPS(NGROUPS),
    .DEPTH_SUM(DEPTH_SUM), .WIN_W(WIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hitX(hitX), .hitY(hitY),
    .windowLen(windowLen), .status(dpStatus),
    .timingX(timingX), .timingY(timingY)
  );

  lsct_control #(.DEAD_W(DEAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .status(dpStatus),
    .comboEnable(comboEnable), .deadTime(deadTime), .trigOut(trigOut)
  );
endmodule

// File: rtl/layer_coinc_trig_chk.sv
module layer_coinc_trig_chk
  import lsct_pkg::*;
#(
  parameter int NUM_LAYERS = 14,
  parameter int NSTRIPS    = 32,
  parameter int WIN_W      = 6,
  parameter int DEAD_W     = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_LAYERS*NSTRIPS-1:0] hitX,
  input logic [NUM_LAYERS*NSTRIPS-1:0] hitY,
  input logic [WIN_W-1:0]              windowLen,
  input logic [FOLD_MAX-1:0]           comboEnable,
  input logic [DEAD_W-1:0]             deadTime,
  input logic                          trigOut,
  input logic [NUM_LAYERS-1:0]         timingX,
  input logic [NUM_LAYERS-1:0]         timingY,
  input comboStatus_t                  status
);
  logic [31:0]       since;
  logic              seen;
  logic [DEAD_W-1:0] lastDead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      since <= '0; seen <= 1'b0; lastDead <= '0;
    end else if (trigOut) begin
      since <= '0; seen <= 1'b1; lastDead <= deadTime;
    end else if (since != '1) begin
      since <= since + 1'b1;
    end
  end

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  p_dead_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && seen) |-> (since >= 32'(lastDead)));

  p_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(|((status.viewX | status.viewY) & comboEnable)));

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_tim
    p_timing_x_r10: assert property (@(posedge clk) disable iff (!rstN)
      ((|hitX[l*NSTRIPS +: NSTRIPS]) && windowLen != '0) |-> ##2 timingX[l]);
    p_timing_y_r10: assert property (@(posedge clk) disable iff (!rstN)
      ((|hitY[l*NSTRIPS +: NSTRIPS]) && windowLen != '0) |-> ##2 timingY[l]);
  end
endmodule

bind layer_coinc_trig layer_coinc_trig_chk #(
  .NUM_LAYERS(NUM_LAYERS), .NSTRIPS(NSTRIPS), .WIN_W(WIN_W), .DEAD_W(DEAD_W)
) u_chk (.*, .status(dpStatus));

// File: tb/tb_layer_coinc_trig.sv
module tb_layer_coinc_trig;
  localparam int NL = 14;
  localparam int NS = 32;
  typedef logic [NL*NS-1:0] bus_t;
  typedef struct {int cyc; int kind; int layer; logic exp; string tag;} expItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  bus_t hitX = '0, hitY = '0;
  logic [5:0]  windowLen = 6'd4;
  logic [3:0]  comboEnable = 4'hF;
  logic [15:0] deadTime = 16'd3;
  logic trigOut;
  logic [NL-1:0] timingX, timingY;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  expItem_t expQ[$];

  layer_coinc_trig dut (
    .clk(clk), .rstN(rstN), .hitX(hitX), .hitY(hitY), .windowLen(windowLen),
    .comboEnable(comboEnable), .deadTime(deadTime), .trigOut(trigOut),
    .timingX(timingX), .timingY(timingY)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bus_t addHit(input bus_t v, input int layer, input int strip);
    bus_t r = v;
    r[layer*NS + strip] = 1'b1;
    return r;
  endfunction

  task automatic expectTrig(input int at, input logic e, input string tag);
    expItem_t it = '{cyc: at, kind: 0, layer: 0, exp: e, tag: tag};
    expQ.push_back(it);
  endtask

  task automatic expectTiming(input int at, input int view, input int layer,
                              input logic e, input string tag);
    expItem_t it = '{cyc: at, kind: view, layer: layer, exp: e, tag: tag};
    expQ.push_back(it);
  endtask

  // drive a one-cycle hit pattern; k is the cycle count before its sampling edge
  task automatic pulseHits(input bus_t hx, input bus_t hy, output int k);
    @(negedge clk);
    hitX = hx; hitY = hy; k = cyc;
    @(negedge clk);
    hitX = '0; hitY = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare queued expectations, flag unpredicted pulses
  initial begin
    bit sawTrig;
    logic act;
    forever begin
      @(posedge clk); #2;
      cyc++;
      sawTrig = 0;
      for (int i = expQ.size() - 1; i >= 0; i--) begin
        if (expQ[i].cyc == cyc) begin
          if (expQ[i].kind == 0) begin act = trigOut; sawTrig = 1; end
          else if (expQ[i].kind == 1) act = timingX[expQ[i].layer];
          else act = timingY[expQ[i].layer];
          check(expQ[i].tag, act, expQ[i].exp);
          expQ.delete(i);
        end
      end
      if (!sawTrig && rstN && trigOut === 1'b1)
        check("R8/R9 unpredicted trigger pulse", trigOut, 1'b0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bus_t bx, by;
    int k, kA;
    idle(3);
    check("R1 trigOut in reset", trigOut, 1'b0);
    check("R1 timingX in reset", |timingX, 1'b0);
    check("R1 timingY in reset", |timingY, 1'b0);
    rstN = 1'b1;
    idle(1);
    check("R1 trigOut after reset", trigOut, 1'b0);
    idle(2);

    // R4: (1,5) across layers 2..6, strips from several stride positions
    bx = '0;
    bx = addHit(bx, 2, 0); bx = addHit(bx, 3, 9); bx = addHit(bx, 4, 18);
    bx = addHit(bx, 5, 27); bx = addHit(bx, 6, 31);
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b1, "R4 1x5 fires");
    expectTrig(k + 5, 1'b0, "R8 single cycle");
    expectTiming(k + 2, 1, 2, 1'b1, "R10 timingX layer2 high");
    expectTiming(k + 2, 1, 0, 1'b0, "R10 timingX layer0 idle");
    expectTiming(k + 2, 2, 2, 1'b0, "R10 timingY layer2 idle");
    idle(12);

    // R4: four layers only, depth short
    bx = '0;
    for (int l = 2; l < 6; l++) bx = addHit(bx, l, 0);
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b0, "R4 1x4 must not fire");
    idle(12);

    // R3: wrap adjacency, groups 7 and 0
    comboEnable = 4'b0010;
    bx = '0;
    for (int l = 5; l < 9; l++) begin bx = addHit(bx, l, 31); bx = addHit(bx, l, 8); end
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b1, "R3 wrap 2x4 fires");
    idle(12);

    // R2: strips 3 and 28 are groups 3 and 4
    bx = '0;
    for (int l = 9; l < 13; l++) begin bx = addHit(bx, l, 3); bx = addHit(bx, l, 28); end
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b1, "R2 stride grouping 2x4");
    idle(12);

    // R3: groups 0 and 2 are not adjacent
    bx = '0;
    for (int l = 5; l < 9; l++) begin bx = addHit(bx, l, 0); bx = addHit(bx, l, 2); end
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b0, "R3 non-adjacent no 2-fold");
    idle(12);

    // R5: (3,3) in view Y at the top layers
    comboEnable = 4'b0100;
    by = '0;
    for (int l = 11; l < 14; l++) begin
      by = addHit(by, l, 5); by = addHit(by, l, 14); by = addHit(by, l, 23);
    end
    pulseHits('0, by, k);
    expectTrig(k + 4, 1'b1, "R5 view Y 3x3 fires");
    idle(12);

    // R5: views do not combine
    comboEnable = 4'hF;
    bx = '0; by = '0;
    for (int l = 0; l < 3; l++) bx = addHit(bx, l, 0);
    for (int l = 3; l < 5; l++) by = addHit(by, l, 0);
    pulseHits(bx, by, k);
    expectTrig(k + 4, 1'b0, "R5 mixed views no fire");
    idle(12);

    // R4 (4,2) and R7 mask
    comboEnable = 4'b1000;
    bx = '0;
    for (int l = 0; l < 2; l++) begin
      bx = addHit(bx, l, 6); bx = addHit(bx, l, 7);
      bx = addHit(bx, l, 8); bx = addHit(bx, l, 9);
    end
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b1, "R4 4x2 fires");
    idle(12);
    comboEnable = 4'b0111;
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b0, "R7 masked 4x2 no fire");
    idle(12);

    // R6 window: gap 3 < 4 coincides, gap 4 does not
    comboEnable = 4'hF;
    bx = '0; by = '0;
    for (int l = 0; l < 3; l++) bx = addHit(bx, l, 1);
    for (int l = 3; l < 5; l++) by = addHit(by, l, 1);
    pulseHits(bx, '0, kA);
    expectTrig(kA + 4, 1'b0, "R6 partial set alone");
    idle(1);
    pulseHits(by, '0, k);
    expectTrig(k + 4, 1'b1, "R6 gap below window fires");
    idle(12);
    pulseHits(bx, '0, kA);
    idle(2);
    pulseHits(by, '0, k);
    expectTrig(k + 4, 1'b0, "R6 gap equal window no fire");
    idle(12);

    // R6: zero window suppresses everything
    windowLen = 6'd0;
    bx = '0;
    for (int l = 0; l < 5; l++) bx = addHit(bx, l, 1);
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b0, "R6 zero window no fire");
    expectTiming(k + 2, 1, 0, 1'b0, "R6 zero window timing low");
    idle(12);

    // R9 dead time: second start four cycles after pulse
    windowLen = 6'd2;
    deadTime = 16'd5;
    bx = '0;
    for (int l = 0; l < 5; l++) bx = addHit(bx, l, 4);
    pulseHits(bx, '0, kA);
    expectTrig(kA + 4, 1'b1, "R9 first pulse");
    idle(2);
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b0, "R9 retrigger inside dead time dropped");
    idle(15);
    deadTime = 16'd3;
    pulseHits(bx, '0, kA);
    expectTrig(kA + 4, 1'b1, "R9 first pulse short dead");
    idle(2);
    pulseHits(bx, '0, k);
    expectTrig(k + 4, 1'b1, "R9 retrigger after dead time accepted");
    idle(15);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule